// File: doc/BRIEF.md
# Six-Channel Staggered PWM Dimmer

The block drives six LED channel gates from one 8-bit brightness code. A period counter runs from 0 to 254 and advances on each clock where the count-clock enable is high, so a PWM period is 255 ticks long. Each enabled channel gets an offset inside that period. In compare mode a channel is high while its offset-adjusted count is below the duty code. Offsets come either from a programmable count step or from an equal split of the period across the enabled channels only. This staggers the channel load over time instead of switching every string at once.

Duty can come from the brightness input or from a measurement of an external PWM input over the previous period. In direct mode each enabled channel copies the external PWM input, delayed by a multiple of the phase step counted in ticks of a separate reference enable. The duty, enable mask, equal-spacing select and phase step are captured only at the period boundary, so a configuration change never cuts a pulse short. The backlight-on input gates every output at once.

Top module: `dim_stagger_top`

## Requirements
- R1: While rst_n is low, gate_o is all zero. After reset the period count is 0, the captured duty is 255, all six channels are enabled, and every offset is 0 until the first period boundary.
- R2: The period count advances by one on each clock edge with tick_i high and wraps from 254 to 0. In compare mode (direct_i=0), gate_o bit k is high when ((count - offset_k) mod 255) < duty. gate_o is registered and reflects the count held before the edge.
- R3: A captured duty of 0 keeps every channel low for the whole period. A duty of 255 keeps every enabled channel high for the whole period.
- R4: When on_i is low at a clock edge, gate_o is all zero after that edge, in every mode.
- R5: A channel whose captured mask bit is 0 is held low, and it is not counted when ranks or the equal-spacing divisor are formed.
- R6: With equal_i=0, the channel of rank r has offset (r * step) mod 255. Rank r is the number of enabled channels with a lower index, so the lowest enabled channel has offset 0.
- R7: With equal_i=1, the spacing is floor(255 / N), where N is the number of enabled channels, and the channel of rank r has offset r * spacing. With N = 0 no channel is driven.
- R8: bright_i, mask_i, equal_i, step_i and sel_ext_i are sampled only at the edge where tick_i is high and the count is 254. They govern the period that starts at count 0.
- R9: When sel_ext_i=1 at that boundary edge, the new duty is the number of tick_i edges in the ending period, the last one included, at which pwm_i was high.
- R10: With direct_i=1, pwm_i is shifted into a history at each edge with ref_tick_i high. Position 0 is the latest sample, and the history is zero after reset. The channel of rank r outputs history position r * step. Duty and offset do not apply in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-clock enable; one period count per high cycle |
| ref_tick_i | input | 1 | Reference enable that paces the direct-mode delay |
| pwm_i | input | 1 | External PWM input |
| on_i | input | 1 | Backlight on; low forces all gates low |
| sel_ext_i | input | 1 | Duty source: 1 = measured pwm_i, 0 = bright_i |
| direct_i | input | 1 | Direct pass-through mode |
| equal_i | input | 1 | Equal spacing over enabled channels |
| bright_i | input | 8 | Brightness code |
| mask_i | input | 6 | Channel enable mask, bit k = channel k |
| step_i | input | 7 | Phase step in counts (compare) or reference ticks (direct) |
| gate_o | output | 6 | Channel gate outputs |

## Verification
The hardest state to reach is direct mode with the largest step and all six channels enabled. The last channel then reads a sample taken 635 reference ticks earlier, so the history must fill before that channel shows anything but zero. The bench runs direct mode long enough to fill the history at a paced reference enable, with pseudo-random input bits. The bench also changes the configuration at arbitrary points inside a period and thins the count enable. A model that captures settings only at the boundary edge exposes any early update. The equal-split masks include the empty mask and a single channel.

// File: rtl/dim_pkg.sv
package dim_pkg;

    typedef enum logic {
        DUTY_FROM_REG = 1'b0,
        DUTY_FROM_EXT = 1'b1
    } duty_src_e;

    typedef enum logic {
        GATE_COMPARE = 1'b0,
        GATE_DIRECT  = 1'b1
    } gate_mode_e;

endpackage

// File: rtl/dim_period_ctr.sv
module dim_period_ctr #(
    parameter int PERIOD = 255,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    assign wrap_o = tick_i && (ctr_q.cnt == CW'(PERIOD - 1));
    assign cnt_o  = ctr_q.cnt;

    always_comb begin
        ctr_d = ctr_q;
        if (tick_i) begin
            if (wrap_o) ctr_d.cnt = '0;
            else        ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

endmodule

// File: rtl/dim_duty_meter.sv
module dim_duty_meter #(
    parameter int PERIOD = 255,
    parameter int BW     = 8,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wrap_i,
    input  logic          pwm_i,
    output logic [BW-1:0] duty_o
);

    localparam int MAXD = (1 << BW) - 1;

    typedef struct packed {
        logic [CW-1:0] acc;
    } meter_t;

    meter_t met_d, met_q;
    int     total;

    // count of high samples including the one taken at this edge
    always_comb begin
        total  = int'(met_q.acc) + int'(pwm_i);
        duty_o = (total > MAXD) ? BW'(MAXD) : BW'(total);
    end

    always_comb begin
        met_d = met_q;
        if (tick_i) begin
            if (wrap_i) met_d.acc = '0;
            else        met_d.acc = met_q.acc + CW'(pwm_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) met_q <= '0;
        else        met_q <= met_d;
    end

endmodule

// File: rtl/dim_phase_plan.sv
module dim_phase_plan #(
    parameter int CH     = 6,
    parameter int PERIOD = 255,
    parameter int PSW    = 7,
    parameter int CW     = $clog2(PERIOD),
    parameter int DW     = 10
) (
    input  logic [CH-1:0]          mask_i,
    input  logic                   equal_i,
    input  logic [PSW-1:0]         step_i,
    output logic [CH-1:0][CW-1:0]  off_o,
    output logic [CH-1:0][DW-1:0]  dly_o
);

    always_comb begin
        int n_on;
        int spacing;
        int rank;
        n_on = $countones(mask_i);
        if (equal_i) spacing = (n_on == 0) ? 0 : PERIOD / n_on;
        else         spacing = int'(step_i);
        rank = 0;
        for (int k = 0; k < CH; k++) begin
            off_o[k] = CW'((rank * spacing) % PERIOD);
            dly_o[k] = DW'(rank * int'(step_i));
            if (mask_i[k]) rank = rank + 1;
        end
    end

endmodule

// File: rtl/dim_delay_line.sv
module dim_delay_line #(
    parameter int DEPTH = 636
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             pwm_i,
    output logic [DEPTH-1:0] hist_o
);

    typedef struct packed {
        logic [DEPTH-1:0] hist;
    } line_t;

    line_t line_d, line_q;

    assign hist_o = line_q.hist;

    always_comb begin
        line_d = line_q;
        if (ref_tick_i) line_d.hist = {line_q.hist[DEPTH-2:0], pwm_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

endmodule

// File: rtl/dim_stagger_top.sv
module dim_stagger_top
    import dim_pkg::*;
#(
    parameter int CH     = 6,
    parameter int PERIOD = 255,
    parameter int BW     = 8,
    parameter int PSW    = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           ref_tick_i,
    input  logic           pwm_i,
    input  logic           on_i,
    input  logic           sel_ext_i,
    input  logic           direct_i,
    input  logic           equal_i,
    input  logic [BW-1:0]  bright_i,
    input  logic [CH-1:0]  mask_i,
    input  logic [PSW-1:0] step_i,
    output logic [CH-1:0]  gate_o
);

    localparam int CW       = $clog2(PERIOD);
    localparam int STEP_MAX = (1 << PSW) - 1;
    localparam int DEPTH    = (CH - 1) * STEP_MAX + 1;
    localparam int DW       = $clog2(DEPTH);

    typedef struct packed {
        logic [BW-1:0]  duty;
        logic [CH-1:0]  mask;
        logic           equal;
        logic [PSW-1:0] step;
        logic [CH-1:0]  gate;
    } top_t;

    top_t st_d, st_q;

    logic [CW-1:0]          cnt;
    logic                   wrap;
    logic [BW-1:0]          meas_duty;
    logic [CH-1:0][CW-1:0]  off;
    logic [CH-1:0][DW-1:0]  dly;
    logic [DEPTH-1:0]       hist;
    duty_src_e              src;
    gate_mode_e             mode;

    assign src    = duty_src_e'(sel_ext_i);
    assign mode   = gate_mode_e'(direct_i);
    assign gate_o = st_q.gate;

    dim_period_ctr #(.PERIOD(PERIOD), .CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    dim_duty_meter #(.PERIOD(PERIOD), .BW(BW), .CW(CW)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .wrap_i (wrap),
        .pwm_i  (pwm_i),
        .duty_o (meas_duty)
    );

    dim_phase_plan #(.CH(CH), .PERIOD(PERIOD), .PSW(PSW), .CW(CW), .DW(DW)) u_plan (
        .mask_i  (st_q.mask),
        .equal_i (st_q.equal),
        .step_i  (st_q.step),
        .off_o   (off),
        .dly_o   (dly)
    );

    dim_delay_line #(.DEPTH(DEPTH)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .pwm_i      (pwm_i),
        .hist_o     (hist)
    );

    always_comb begin
        int   rel;
        logic hit;
        st_d = st_q;
        // settings move into the shadow only at the period boundary
        if (wrap) begin
            st_d.duty  = (src == DUTY_FROM_EXT) ? meas_duty : bright_i;
            st_d.mask  = mask_i;
            st_d.equal = equal_i;
            st_d.step  = step_i;
        end
        for (int k = 0; k < CH; k++) begin
            rel = 0;
            hit = 1'b0;
            if (mode == GATE_DIRECT) begin
                hit = hist[dly[k]];
            end else begin
                rel = (int'(cnt) + PERIOD - int'(off[k])) % PERIOD;
                hit = rel < int'(st_q.duty);
            end
            st_d.gate[k] = on_i && st_q.mask[k] && hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.duty  <= '1;
            st_q.mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dim_stagger_chk.sv
module dim_stagger_chk #(
    parameter int CH     = 6,
    parameter int PERIOD = 255,
    parameter int BW     = 8,
    parameter int CW     = $clog2(PERIOD)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          on_i,
    input logic          direct_i,
    input logic [CH-1:0] gate_o,
    input logic [CW-1:0] cnt,
    input logic [BW-1:0] duty_s,
    input logic [CH-1:0] mask_s
);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(PERIOD));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt != CW'(PERIOD - 1)) |=> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt));

    // R3
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_s == '0 && !direct_i) |=> (gate_o == '0));

    // R3
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_s == BW'(PERIOD) && !direct_i && on_i) |=> (gate_o == $past(mask_s)));

    // R4
    backlight_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> (gate_o == '0));

    // R5
    masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gate_o & ~$past(mask_s)) == '0));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && cnt == CW'(PERIOD - 1)) |=> ($stable(duty_s) && $stable(mask_s)));

endmodule

bind dim_stagger_top dim_stagger_chk #(
    .CH(CH), .PERIOD(PERIOD), .BW(BW), .CW(CW)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .on_i     (on_i),
    .direct_i (direct_i),
    .gate_o   (gate_o),
    .cnt      (cnt),
    .duty_s   (st_q.duty),
    .mask_s   (st_q.mask)
);

// File: tb/test_dim_stagger_top.sv
module test_dim_stagger_top;

    localparam int CLK_PERIOD = 10;
    localparam int CH         = 6;
    localparam int PER        = 255;
    localparam int DEPTH      = 636;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1, ref_tick = 1'b1, pwm = 1'b0;
    logic       on = 1'b0, sel = 1'b0, direct = 1'b0, equal = 1'b0;
    logic [7:0] bright = 8'h10;
    logic [5:0] mask = 6'h3F;
    logic [6:0] step = 7'd0;
    logic [5:0] gate;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;
    bit    done = 1'b0;

    // stimulus generator controls
    int          tick_div = 1, ref_div = 1, pwm_mode = 0, pwm_hi = 0, pwm_len = 1;
    logic        pwm_lvl = 1'b0;
    int          tcnt = 0, rcnt = 0, pcnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int         cnt_m = 0, acc_m = 0;
    logic [7:0] sh_duty = 8'hFF;
    logic [5:0] sh_mask = 6'h3F;
    logic       sh_eq = 1'b0;
    logic [6:0] sh_step = 7'd0;
    logic [DEPTH-1:0] hist_m = '0;
    logic [5:0] exp_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dim_stagger_top i_dim_stagger_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .ref_tick_i (ref_tick),
        .pwm_i      (pwm),
        .on_i       (on),
        .sel_ext_i  (sel),
        .direct_i   (direct),
        .equal_i    (equal),
        .bright_i   (bright),
        .mask_i     (mask),
        .step_i     (step),
        .gate_o     (gate)
    );

    function automatic logic [5:0] model_gate();
        logic [5:0] g = '0;
        int n = $countones(sh_mask);
        int sp = sh_eq ? ((n == 0) ? 0 : PER / n) : int'(sh_step);
        int r = 0;
        for (int k = 0; k < CH; k++) begin
            if (sh_mask[k]) begin
                if (direct) g[k] = hist_m[r * int'(sh_step)];
                else        g[k] = (((cnt_m - (r * sp) % PER) % PER + PER) % PER) < int'(sh_duty);
                r++;
            end
        end
        return on ? g : 6'h00;
    endfunction

    // model advances on the same edges the design does
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_m = 0; acc_m = 0; sh_duty = 8'hFF; sh_mask = 6'h3F;
            sh_eq = 1'b0; sh_step = 7'd0; hist_m = '0; exp_m = '0;
        end else begin
            exp_m = model_gate();
            if (ref_tick) hist_m = {hist_m[DEPTH-2:0], pwm};
            if (tick) begin
                if (cnt_m == PER - 1) begin
                    sh_duty = sel ? 8'(acc_m + int'(pwm)) : bright;
                    sh_mask = mask; sh_eq = equal; sh_step = step;
                    acc_m = 0; cnt_m = 0;
                end else begin
                    acc_m = acc_m + int'(pwm);
                    cnt_m = cnt_m + 1;
                end
            end
        end
    end

    // input pattern generators, driven away from the active edge
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % tick_div;
        tick = (tcnt == 0);
        rcnt = (rcnt + 1) % ref_div;
        ref_tick = (rcnt == 0);
        pcnt = (pcnt + 1) % pwm_len;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (pwm_mode)
            1:       pwm = (pcnt < pwm_hi);
            2:       pwm = lfsr[0];
            default: pwm = pwm_lvl;
        endcase
    end

    task automatic check(input logic [5:0] act, input logic [5:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: gate_o=%b expected=%b at %0t", cur_req, act, expv, $time);
        end
    endtask

    always @(negedge clk) if (chk_en && !done) check(gate, exp_m);

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs low in reset, even with backlight on
        on = 1'b1;
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check(gate, 6'h00);
        rst_n = 1'b1;
        chk_en = 1'b1;
        // R1: first period runs with duty 255 and zero offsets
        run(PER);

        // R4: backlight off forces every gate low
        cur_req = "R4";
        on = 1'b0; run(150);
        on = 1'b1; run(100);

        // R2 R3 R6: brightness by step sweep, all channels enabled
        foreach (sweep_b[i]) ;
        for (int bi = 0; bi < 6; bi++) begin
            for (int si = 0; si < 4; si++) begin
                logic [7:0] bv [6] = '{8'd0, 8'd1, 8'd2, 8'd100, 8'd254, 8'd255};
                logic [6:0] sv [4] = '{7'd0, 7'd1, 7'd40, 7'd127};
                bright = bv[bi]; step = sv[si];
                cur_req = (bv[bi] == 0 || bv[bi] == 255) ? "R3" : ((si == 0) ? "R2" : "R6");
                run(2 * PER);
            end
        end

        // R5 R7: equal split over several masks, including empty and single
        equal = 1'b1;
        for (int mi = 0; mi < 6; mi++) begin
            logic [5:0] mv [6] = '{6'h3F, 6'h15, 6'h01, 6'h00, 6'h2C, 6'h20};
            for (int bi = 0; bi < 2; bi++) begin
                mask = mv[mi]; bright = (bi == 0) ? 8'd60 : 8'd200;
                cur_req = (mv[mi] == 6'h3F) ? "R7" : "R5";
                run(2 * PER);
            end
        end

        // R5 R6: fixed step with gaps in the mask
        equal = 1'b0; mask = 6'h2C; step = 7'd50; bright = 8'd90;
        cur_req = "R6"; run(2 * PER);

        // R8: settings changed at arbitrary points inside periods
        cur_req = "R8";
        mask = 6'h3F; step = 7'd17; bright = 8'd30;
        for (int i = 0; i < 25; i++) begin
            run(97);
            bright = bright + 8'd37;
            step = step + 7'd13;
            mask = mask ^ 6'(i * 5 + 1);
            equal = i[2];
        end
        equal = 1'b0; mask = 6'h3F;

        // R2: count enable held low on two of every three clocks
        cur_req = "R2";
        tick_div = 3; bright = 8'd100; step = 7'd20;
        run(3 * 3 * PER);

        // R9: duty taken from the measured external input
        cur_req = "R9";
        sel = 1'b1; pwm_mode = 1; pwm_len = 37;
        for (int hi = 0; hi < 3; hi++) begin
            for (int td = 1; td < 3; td++) begin
                int hv [3] = '{0, 11, 37};
                pwm_hi = hv[hi]; tick_div = td;
                run(2 * td * PER + 10);
            end
        end
        tick_div = 1; sel = 1'b0;

        // R10: direct pass-through with paced reference delay
        cur_req = "R10";
        direct = 1'b1; pwm_mode = 2; ref_div = 2;
        for (int mi = 0; mi < 2; mi++) begin
            for (int si = 0; si < 3; si++) begin
                logic [6:0] sv [3] = '{7'd0, 7'd3, 7'd127};
                mask = (mi == 0) ? 6'h3F : 6'h1A;
                step = sv[si];
                run(1800);
            end
        end
        // R4: backlight off also silences direct mode
        cur_req = "R4";
        on = 1'b0; run(60);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    int sweep_b [1];

endmodule